// File: doc/BRIEF.md
# Core-Side Loop Buffer Fetch Selector

This block sits in the processor core, at the point where fetched instructions enter decode. For every cycle it picks the instruction to issue from one of two places: the instruction content bus coming from the memory side, or a small tagless loop buffer held locally in the core. The memory side decides the loop state and sends it as a 2-bit code. The selector follows that code. It records bus words into the buffer while a loop is being captured. It replays them in order while the loop repeats, which leaves the content bus idle. The selector does not detect loops itself.

A fourth code supports nested loops. In that code the idle content bus carries a buffer location instead of an instruction. The selector issues the word stored at that location, and sequential replay then continues from the next location. This lets the memory side reorder replay when the nesting changes the sequence. The block also keeps the previous cycle's code and predicted-taken bit. When replay or capture is abandoned, it reports an exit event that carries enough information to classify the misprediction by direction and by the mode that was aborted.

Top module: `lbsel_fetch`

## Requirements
- R1: After reset the buffer is empty and the previous code is idle. With code 00 applied, `instr_out` equals `bus_word`, and `idx_err` and `exit_evt` are 0.
- R2: Code 00 (idle) issues `bus_word` with `idx_err` low. It neither writes the buffer nor moves the write or read pointer, so a later replay returns the previously captured words.
- R3: Code 01 (fill) issues `bus_word` in the same cycle and stores it at the write pointer. The write pointer then advances by one, and the filled count equals the write pointer.
- R4: A fill cycle whose previous code was 00 stores at location 0, which restarts the buffer. A fill cycle that follows code 10 or 11 appends after the last stored word. Every fill cycle resets the read pointer to 0.
- R5: Code 10 (active) issues the buffer word at the read pointer. The read pointer then advances, wrapping to 0 after the last filled location.
- R6: Code 11 (indexed) treats the whole 32-bit `bus_word` as an unsigned location. If the location is below the filled count, the word stored there is issued and the next active cycle continues from location+1, wrapping to 0 after the last filled location.
- R7: Code 11 with a location at or above the filled count raises `idx_err`, issues `bus_word` unchanged and leaves the read pointer where it was.
- R8: Code 10 while the buffer is empty raises `idx_err` and issues `bus_word`.
- R9: The buffer holds DEPTH (32) words. Fill cycles beyond that store nothing, the filled count stays at 32, and replay wraps after location 31.
- R10: `exit_evt` is 1 exactly in a code-00 cycle whose previous cycle had a nonzero code. In that cycle `exit_from` is the previous code and `exit_pred_taken` is the previous cycle's `pred_taken`. Outside an exit both fields are 0.
- R11: `idx_err` is only ever raised under codes 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_code | input | 2 | Loop state from the memory side: 00 idle, 01 fill, 10 active, 11 indexed |
| bus_word | input | 32 | Instruction content bus; carries a buffer location under code 11 |
| pred_taken | input | 1 | Predicted-taken bit sent with the current fetch |
| instr_out | output | 32 | Instruction issued to decode this cycle |
| idx_err | output | 1 | Replay request could not be served from the buffer |
| exit_evt | output | 1 | Capture or replay abandoned this cycle |
| exit_from | output | 2 | Code that was in force before the exit |
| exit_pred_taken | output | 1 | Predicted-taken bit of the cycle before the exit |

## Verification
The instruction and error outputs are combinational on the current code, the bus word and registered pointers, so they are due in the same cycle as the stimulus. The bench drives on the falling edge and samples two nanoseconds later, before the next rising edge. Writes and pointer moves take effect at the rising edge that closes a cycle, so the bench expects their results only in the following cycle: a replay word one cycle after its fill, and a resumed sequence one cycle after an index. The exit fields depend on the previous cycle's code and predicted-taken bit. The bench therefore carries its own copy of those two values from one cycle to the next and compares against them in the same cycle.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

  typedef enum logic [1:0] {
    LB_IDLE    = 2'b00,
    LB_FILL    = 2'b01,
    LB_ACTIVE  = 2'b10,
    LB_INDEXED = 2'b11
  } lb_code_t;

  // next sequential location, wrapping after the last filled entry
  function automatic int unsigned lb_wrap_next(input int unsigned ptr,
                                               input int unsigned cnt);
    return (ptr + 1 >= cnt) ? 0 : ptr + 1;
  endfunction

  // a location is servable only when it lies below the filled count
  function automatic logic lb_in_range(input logic [31:0] loc,
                                       input int unsigned cnt);
    return (loc < cnt);
  endfunction

endpackage

// File: rtl/lbsel_store.sv
module lbsel_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lbsel_ptrs.sv
module lbsel_ptrs
  import lbsel_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lb_code_t      code,
  input  lb_code_t      prev_code,
  input  logic [31:0]   loc_word,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          idx_ok,
  output logic          act_ok
);

  logic          restart;
  logic [CW-1:0] wtarget;

  assign restart = (code == LB_FILL) && (prev_code == LB_IDLE);
  assign wtarget = restart ? '0 : wr_ptr;
  assign we      = (code == LB_FILL) && (wtarget < CW'(DEPTH));
  assign waddr   = wtarget[AW-1:0];
  assign idx_ok  = (code == LB_INDEXED) && lb_in_range(loc_word, 32'(wr_ptr));
  assign act_ok  = (code == LB_ACTIVE) && (wr_ptr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      case (code)
        LB_FILL: begin
          if (we) wr_ptr <= wtarget + CW'(1);
          rd_ptr <= '0;
        end
        LB_ACTIVE: begin
          if (act_ok)
            rd_ptr <= AW'(lb_wrap_next(32'(rd_ptr), 32'(wr_ptr)));
        end
        LB_INDEXED: begin
          if (idx_ok)
            rd_ptr <= AW'(lb_wrap_next(32'(loc_word[AW-1:0]), 32'(wr_ptr)));
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lbsel_hist.sv
module lbsel_hist
  import lbsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lb_code_t code,
  input  logic     pred_taken,
  output lb_code_t prev_code,
  output logic     exit_evt,
  output logic [1:0] exit_from,
  output logic     exit_pred_taken
);

  logic last_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= LB_IDLE;
      last_pt   <= 1'b0;
    end else begin
      prev_code <= code;
      last_pt   <= pred_taken;
    end
  end

  assign exit_evt        = (code == LB_IDLE) && (prev_code != LB_IDLE);
  assign exit_from       = exit_evt ? prev_code : 2'b00;
  assign exit_pred_taken = exit_evt & last_pt;

endmodule

// File: rtl/lbsel_fetch.sv
module lbsel_fetch
  import lbsel_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    loop_code,
  input  logic [DW-1:0] bus_word,
  input  logic          pred_taken,
  output logic [DW-1:0] instr_out,
  output logic          idx_err,
  output logic          exit_evt,
  output logic [1:0]    exit_from,
  output logic          exit_pred_taken
);

  lb_code_t      code;
  lb_code_t      prev_code;
  logic          we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [CW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          idx_ok;
  logic          act_ok;
  logic [DW-1:0] rdata;
  logic [31:0]   loc_word;

  assign code     = lb_code_t'(loop_code);
  assign loc_word = 32'(bus_word);
  assign raddr    = (code == LB_INDEXED) ? bus_word[AW-1:0] : rd_ptr;

  lbsel_hist u_hist (
    .clk             (clk),
    .rst_n           (rst_n),
    .code            (code),
    .pred_taken      (pred_taken),
    .prev_code       (prev_code),
    .exit_evt        (exit_evt),
    .exit_from       (exit_from),
    .exit_pred_taken (exit_pred_taken)
  );

  lbsel_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (code),
    .prev_code (prev_code),
    .loc_word  (loc_word),
    .we        (we),
    .waddr     (waddr),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .idx_ok    (idx_ok),
    .act_ok    (act_ok)
  );

  lbsel_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (bus_word),
    .raddr (raddr),
    .rdata (rdata)
  );

  always_comb begin
    instr_out = bus_word;
    idx_err   = 1'b0;
    case (code)
      LB_ACTIVE: begin
        if (act_ok) instr_out = rdata;
        idx_err = !act_ok;
      end
      LB_INDEXED: begin
        if (idx_ok) instr_out = rdata;
        idx_err = !idx_ok;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lbsel_fetch_chk.sv
module lbsel_fetch_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    loop_code,
  input logic [DW-1:0] bus_word,
  input logic [DW-1:0] instr_out,
  input logic          idx_err,
  input logic          exit_evt,
  input logic [CW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [1:0]    prev_code
);

  assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_code == 2'b00 |-> (instr_out == bus_word) && !idx_err);

  assert_fill_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_code == 2'b01) && (prev_code == 2'b00) |=> wr_ptr == CW'(1));

  assert_rd_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr != '0 |-> CW'(rd_ptr) < wr_ptr);

  assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err && (loop_code == 2'b11) |=> rd_ptr == $past(rd_ptr));

  assert_bad_idx_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> instr_out == bus_word);

  assert_cnt_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= CW'(DEPTH));

  assert_exit_seen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_code == 2'b00) && ($past(loop_code) != 2'b00) |-> exit_evt);

  assert_err_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> loop_code[1]);

endmodule

bind lbsel_fetch lbsel_fetch_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loop_code (loop_code),
  .bus_word  (bus_word),
  .instr_out (instr_out),
  .idx_err   (idx_err),
  .exit_evt  (exit_evt),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .prev_code (prev_code)
);

// File: tb/test_lbsel_fetch.sv
module test_lbsel_fetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  loop_code = 2'b00;
  logic [31:0] bus_word = 32'h0;
  logic        pred_taken = 1'b0;
  logic [31:0] instr_out;
  logic        idx_err;
  logic        exit_evt;
  logic [1:0]  exit_from;
  logic        exit_pred_taken;

  int checks = 0;
  int failures = 0;
  logic [1:0] prev_c = 2'b00;
  logic       prev_pt = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  lbsel_fetch i_lbsel_fetch (
    .clk(clk), .rst_n(rst_n), .loop_code(loop_code), .bus_word(bus_word),
    .pred_taken(pred_taken), .instr_out(instr_out), .idx_err(idx_err),
    .exit_evt(exit_evt), .exit_from(exit_from), .exit_pred_taken(exit_pred_taken)
  );

  function automatic logic [31:0] fw(input int r, input int k);
    return 32'h5A00_0000 + 32'(r) * 32'h0001_0000 + 32'(k) * 32'd3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample before the rising edge
  task automatic step(input logic [1:0] c, input logic [31:0] w, input logic pt,
                      input logic [31:0] exp_i, input logic exp_err, input string req);
    logic ex;
    @(negedge clk);
    loop_code = c; bus_word = w; pred_taken = pt;
    #2;
    check(instr_out === exp_i, req, "instr", instr_out, exp_i);
    check(idx_err === exp_err, (exp_err || c[1]) ? req : "R11", "err",
          32'(idx_err), 32'(exp_err));
    ex = (c == 2'b00) && (prev_c != 2'b00);
    check(exit_evt === ex, "R10", "exit_evt", 32'(exit_evt), 32'(ex));
    check(exit_from === (ex ? prev_c : 2'b00), "R10", "exit_from",
          32'(exit_from), 32'(ex ? prev_c : 2'b00));
    check(exit_pred_taken === (ex & prev_pt), "R10", "exit_pt",
          32'(exit_pred_taken), 32'(ex & prev_pt));
    prev_c = c;
    prev_pt = pt;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nlist[5] = '{1, 3, 7, 32, 37};
    bus_word = 32'hDEAD_BEEF;
    #3;
    // R1: reset state
    check(instr_out === 32'hDEAD_BEEF && !idx_err && !exit_evt, "R1", "reset",
          instr_out, 32'hDEAD_BEEF);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(2'b00, 32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0, "R1");
    // R8: replay from an empty buffer
    step(2'b10, 32'h0BAD_0001, 1'b1, 32'h0BAD_0001, 1'b1, "R8");
    step(2'b11, 32'h0, 1'b0, 32'h0, 1'b1, "R8");

    for (int r = 0; r < 5; r++) begin
      int n = nlist[r];
      int nc = (n > 32) ? 32 : n;
      for (int j = 0; j < 2; j++)
        step(2'b00, 32'h1111_0000 + 32'(j), 1'(j), 32'h1111_0000 + 32'(j), 1'b0, "R2");
      for (int k = 0; k < n; k++)
        step(2'b01, fw(r, k), 1'(k), fw(r, k), 1'b0, (k >= 32) ? "R9" : "R3");
      for (int j = 0; j <= 2 * nc; j++)
        step(2'b10, 32'hFFFF_0000, 1'(j + 1), fw(r, j % nc), 1'b0,
             (n > 32) ? "R9" : "R5");
      // idle traffic must leave the captured words untouched
      for (int j = 0; j < 2; j++)
        step(2'b00, 32'h2222_0000 + 32'(j), 1'b1, 32'h2222_0000 + 32'(j), 1'b0, "R2");
      for (int i = 0; i < nc; i++) begin
        step(2'b11, 32'(i), 1'b0, fw(r, i), 1'b0, "R6");
        step(2'b10, 32'hFFFF_0001, 1'b1, fw(r, (i + 1) % nc), 1'b0, "R6");
      end
      step(2'b11, 32'(nc), 1'b0, 32'(nc), 1'b1, "R7");
      step(2'b11, 32'hFFFF_FFF0, 1'b1, 32'hFFFF_FFF0, 1'b1, "R7");
      step(2'b10, 32'hFFFF_0002, 1'b0, fw(r, 1 % nc), 1'b0, "R7");
      step(2'b00, 32'h3333_0000, 1'b0, 32'h3333_0000, 1'b0, "R10");
    end

    // R4: nested capture appends after replay; fill from idle restarts
    for (int k = 0; k < 4; k++) step(2'b01, fw(9, k), 1'b0, fw(9, k), 1'b0, "R4");
    step(2'b10, 32'h0, 1'b0, fw(9, 0), 1'b0, "R4");
    step(2'b10, 32'h0, 1'b0, fw(9, 1), 1'b0, "R4");
    for (int k = 4; k < 7; k++) step(2'b01, fw(9, k), 1'b1, fw(9, k), 1'b0, "R4");
    for (int j = 0; j < 9; j++) step(2'b10, 32'h0, 1'b0, fw(9, j % 7), 1'b0, "R4");
    step(2'b01, fw(10, 0), 1'b1, fw(10, 0), 1'b0, "R4");
    step(2'b00, 32'h4444_0000, 1'b0, 32'h4444_0000, 1'b0, "R10");
    step(2'b01, fw(11, 0), 1'b0, fw(11, 0), 1'b0, "R4");
    step(2'b01, fw(11, 1), 1'b0, fw(11, 1), 1'b0, "R4");
    for (int j = 0; j < 3; j++) step(2'b10, 32'h0, 1'b0, fw(11, j % 2), 1'b0, "R4");
    step(2'b11, 32'd2, 1'b1, 32'd2, 1'b1, "R4");
    step(2'b00, 32'h5555_0000, 1'b0, 32'h5555_0000, 1'b0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule